// File: doc/BRIEF.md
# Dual Programmable Limit Timer

The block holds two independent 32-bit up-counting timers that a processor reaches through a small auxiliary register port. Each timer has a count register, a limit register and a control register. A timer steps its count by one on every enabled cycle. When the count reaches the programmed limit, the next step returns the count to zero, so the timer runs periodically without any reload by software. A timer can flag an interrupt at that moment, and it can be told to stand still while the core reports that it is halted.

Software sets the limit, loads a start count and writes the control register to arm a timer. Any write to a control register also acknowledges that timer's pending interrupt. The register port is a plain single-cycle port: a write takes effect at the clock edge where `bus_we` is high, and `bus_rdata` shows the register selected by `bus_addr` in the same cycle. The port has no back-pressure because every access completes at once. A limit of all ones makes a timer a free-running monotonic counter that wraps through every 32-bit value.

Top module: `dual_limit_timer`

## Requirements
- R1: Timer 0 has its count at address 0x021, control at 0x022 and limit at 0x023. Timer 1 has its count at 0x100, control at 0x101 and limit at 0x102. Each timer's registers act on that timer only.
- R2: Control bit 0 is the interrupt enable and bit 1 is the halt qualifier. A control read returns those two bits, the pending flag in bit 3, and zero elsewhere. Written bits other than 0 and 1 are dropped.
- R3: When a timer steps while its count equals its limit and its interrupt enable is set, its pending flag sets and its `irq` bit is high from the next cycle on. With the enable clear, the flag does not set.
- R4: On a step, a count equal to the limit becomes 0 and any other count increases by one.
- R5: A write of any value to a timer's control register clears that timer's pending flag and drops its `irq` bit in the next cycle.
- R6: With control bit 1 set, a timer does not step in cycles where `core_halted` is high. With bit 1 clear, it steps regardless of `core_halted`.
- R7: A write to a count register loads the written value, and stepping resumes from that value in the next cycle.
- R8: With the limit at 0xFFFFFFFF, the count passes from 0xFFFFFFFF to 0 and keeps counting.
- R9: A read of any address other than the six timer registers returns zero. A write to such an address changes no register.
- R10: After reset all counts, limits and control bits are zero and no interrupt is pending.
- R11: In a cycle where any register of a timer is written, that timer does not step and its pending flag does not set, even if its count equals its limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, same cycle |
| core_halted | input | 1 | High while the core is halted |
| irq | output | 2 | Pending interrupt, one bit per timer |

## Verification
Assertions check on every cycle the wrap to zero at the limit, the load of a written count, the hold under the halt qualifier, the clear of the pending flag after a control write, the suppression of stepping in a write cycle, that at most one register is decoded, and that unmapped reads return zero. Only the bench's scenarios can show that the two timers do not disturb each other over long runs, that irq timing matches over whole periods, the free-running wrap through all ones, and that random mixes of writes, reads and halts keep every register equal to an independently kept model.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 12;
  localparam int NUM_TMR  = 2;
  localparam int NUM_REG  = 3;

  // register offsets from each timer's base address
  localparam int OFS_CNT  = 0;
  localparam int OFS_CTL  = 1;
  localparam int OFS_LIM  = 2;

  // control bit positions
  localparam int CTL_IE   = 0;
  localparam int CTL_NH   = 1;
  localparam int CTL_PEND = 3;

  localparam logic [ADDR_W-1:0] T0_BASE = 12'h021;
  localparam logic [ADDR_W-1:0] T1_BASE = 12'h100;

  function automatic logic [ADDR_W-1:0] tmr_base(input int idx);
    return (idx == 0) ? T0_BASE : T1_BASE;
  endfunction
endpackage

// File: rtl/ltmr_regsel.sv
module ltmr_regsel
  import ltmr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = T0_BASE
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_REG-1:0] sel
);
  for (genvar k = 0; k < NUM_REG; k++) begin : g_sel
    localparam logic [ADDR_W-1:0] REG_ADDR = BASE + ADDR_W'(k);
    assign sel[k] = (addr == REG_ADDR);
  end
endmodule

// File: rtl/ltmr_unit.sv
module ltmr_unit
  import ltmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [NUM_REG-1:0] sel,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               halted,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq
);
  logic [DATA_W-1:0] cnt_q, lim_q;
  logic              ie_q, nh_q, pend_q;
  logic              wr_cnt, wr_ctl, wr_lim, wr_any, step, at_lim;

  assign wr_cnt = we && sel[OFS_CNT];
  assign wr_ctl = we && sel[OFS_CTL];
  assign wr_lim = we && sel[OFS_LIM];
  assign wr_any = wr_cnt || wr_ctl || wr_lim;
  assign at_lim = (cnt_q == lim_q);
  assign step   = !wr_any && !(nh_q && halted);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      ie_q   <= 1'b0;
      nh_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_cnt) cnt_q <= wdata;
      else if (step) cnt_q <= at_lim ? '0 : cnt_q + 1'b1;

      if (wr_lim) lim_q <= wdata;

      if (wr_ctl) begin
        ie_q   <= wdata[CTL_IE];
        nh_q   <= wdata[CTL_NH];
        pend_q <= 1'b0;
      end else if (step && at_lim && ie_q) begin
        pend_q <= 1'b1;
      end
    end
  end

  logic [DATA_W-1:0] ctl_word;
  always_comb begin
    ctl_word           = '0;
    ctl_word[CTL_IE]   = ie_q;
    ctl_word[CTL_NH]   = nh_q;
    ctl_word[CTL_PEND] = pend_q;
  end

  always_comb begin
    rdata = '0;
    if (sel[OFS_CNT]) rdata = cnt_q;
    if (sel[OFS_CTL]) rdata = ctl_word;
    if (sel[OFS_LIM]) rdata = lim_q;
  end

  assign irq = pend_q;

  // R4: a step taken at the limit lands on zero
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_any && !(nh_q && halted) && cnt_q == lim_q) |=> (cnt_q == '0));

  // R7: a count write loads the written value
  p_load_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(wdata)));

  // R6: halt qualifier freezes the count
  p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_any && nh_q && halted) |=> $stable(cnt_q));

  // R5: control write acknowledges the interrupt
  p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> !irq);

  // R11: no pending set in a write cycle
  p_wr_no_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !irq) |=> !irq);

  // R3: pending only rises while enabled
  p_rise_needs_ie_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ie_q));
endmodule

// File: rtl/dual_limit_timer.sv
module dual_limit_timer
  import ltmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              core_halted,
  output logic [NUM_TMR-1:0] irq
);
  logic [NUM_REG-1:0] sel  [NUM_TMR];
  logic [DATA_W-1:0]  rd_t [NUM_TMR];

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    ltmr_regsel #(.BASE(tmr_base(t))) u_sel (
      .addr (bus_addr),
      .sel  (sel[t])
    );
    ltmr_unit u_unit (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (bus_we),
      .sel    (sel[t]),
      .wdata  (bus_wdata),
      .halted (core_halted),
      .rdata  (rd_t[t]),
      .irq    (irq[t])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int t = 0; t < NUM_TMR; t++) bus_rdata |= rd_t[t];
  end

  logic any_hit;
  assign any_hit = (|sel[0]) || (|sel[1]);

  // R1: at most one register decoded per address
  p_one_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel[1], sel[0]}));

  // R9: unmapped addresses read as zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |-> (bus_rdata == '0));
endmodule

// File: tb/sim_dual_limit_timer.sv
`timescale 1ns/1ps
module sim_dual_limit_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        core_halted = 1'b0;
  logic [1:0]  irq;

  always #4 clk = ~clk;

  dual_limit_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_halted(core_halted), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // independent model of the requirements
  logic [31:0] m_cnt [2];
  logic [31:0] m_lim [2];
  logic [1:0]  m_ctl [2];
  logic        m_pend [2];

  function automatic logic [11:0] base_of(input int t);
    return (t == 0) ? 12'h021 : 12'h100;
  endfunction

  function automatic logic [31:0] mread(input logic [11:0] a);
    for (int t = 0; t < 2; t++) begin
      if (a == base_of(t))      return m_cnt[t];
      if (a == base_of(t) + 1)  return {28'd0, m_pend[t], 1'b0, m_ctl[t]};
      if (a == base_of(t) + 2)  return m_lim[t];
    end
    return 32'd0;
  endfunction

  task automatic mstep(input bit we, input logic [11:0] a, input logic [31:0] d, input bit h);
    for (int t = 0; t < 2; t++) begin
      bit hit = we && (a >= base_of(t)) && (a <= base_of(t) + 2);
      if (hit) begin
        if (a == base_of(t)) m_cnt[t] = d;
        else if (a == base_of(t) + 2) m_lim[t] = d;
        else begin m_ctl[t] = d[1:0]; m_pend[t] = 1'b0; end
      end else if (!(m_ctl[t][1] && h)) begin
        if (m_cnt[t] == m_lim[t]) begin
          m_cnt[t] = 32'd0;
          if (m_ctl[t][0]) m_pend[t] = 1'b1;
        end else m_cnt[t] = m_cnt[t] + 1;
      end
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic cyc(input string tag, input bit we, input logic [11:0] a,
                     input logic [31:0] d, input bit h);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; core_halted = h;
    #1;
    chk(tag, "rdata", bus_rdata, mread(a));
    chk(tag, "irq", {30'd0, irq}, {30'd0, m_pend[1], m_pend[0]});
    mstep(we, a, d, h);
  endtask

  task automatic idle(input string tag, input logic [11:0] a, input bit h, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, a, 32'd0, h);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int t = 0; t < 2; t++) begin
      m_cnt[t] = 0; m_lim[t] = 0; m_ctl[t] = 0; m_pend[t] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10: reset state (timers at limit 0 stay at 0)
    cyc("R10", 0, 12'h021, 0, 0); cyc("R10", 0, 12'h022, 0, 0);
    cyc("R10", 0, 12'h023, 0, 0); cyc("R10", 0, 12'h100, 0, 0);
    cyc("R10", 0, 12'h101, 0, 0); cyc("R10", 0, 12'h102, 0, 0);

    // R1 R3 R4: timer 0 periodic with limit 3, interrupt enabled
    cyc("R1", 1, 12'h023, 32'd3, 0);
    cyc("R1", 1, 12'h021, 32'd0, 0);
    cyc("R3", 1, 12'h022, 32'd1, 0);
    idle("R4", 12'h021, 0, 6);
    idle("R3", 12'h022, 0, 2);
    chk("R3", "irq0 high", {31'd0, irq[0]}, 32'd1);
    chk("R1", "timer1 untouched", {31'd0, irq[1]}, 32'd0);

    // R2 R5: control write of extra bits acknowledges and drops upper bits
    cyc("R5", 1, 12'h022, 32'hFFFF_FFF8, 0);
    idle("R2", 12'h022, 0, 2);
    chk("R5", "irq0 cleared", {31'd0, irq[0]}, 32'd0);

    // R6: timer 1 halt qualifier
    cyc("R6", 1, 12'h102, 32'hFFFF_FFFF, 0);
    cyc("R6", 1, 12'h100, 32'd5, 0);
    cyc("R6", 1, 12'h101, 32'd2, 0);
    idle("R6", 12'h100, 1, 4);
    idle("R6", 12'h100, 0, 3);
    cyc("R6", 1, 12'h101, 32'd0, 0);
    idle("R6", 12'h100, 1, 3);

    // R8: free-running wrap through all ones, IE clear so no interrupt (R3)
    cyc("R8", 1, 12'h100, 32'hFFFF_FFFD, 0);
    idle("R8", 12'h100, 0, 5);
    chk("R3", "no irq1 without enable", {31'd0, irq[1]}, 32'd0);

    // R7: reload in mid-run
    cyc("R7", 1, 12'h100, 32'h0000_1000, 0);
    idle("R7", 12'h100, 0, 3);

    // R11: write in the cycle count equals limit
    cyc("R11", 1, 12'h023, 32'd2, 0);
    cyc("R11", 1, 12'h021, 32'd2, 0);
    cyc("R11", 1, 12'h022, 32'd1, 0);
    idle("R11", 12'h021, 0, 1);
    cyc("R11", 1, 12'h021, 32'd2, 0);
    cyc("R11", 1, 12'h023, 32'd2, 0);
    idle("R11", 12'h022, 0, 3);

    // R9: unmapped reads and writes
    cyc("R9", 1, 12'h024, 32'hDEAD_BEEF, 0);
    cyc("R9", 1, 12'h103, 32'hDEAD_BEEF, 0);
    cyc("R9", 1, 12'h020, 32'h1234_5678, 0);
    cyc("R9", 0, 12'h000, 0, 0);
    cyc("R9", 0, 12'hFFF, 0, 0);
    cyc("R9", 0, 12'h023, 0, 0);
    cyc("R9", 0, 12'h102, 0, 0);

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      int pick = $urandom % 8;
      case (pick)
        0: a = 12'h021; 1: a = 12'h022; 2: a = 12'h023;
        3: a = 12'h100; 4: a = 12'h101; 5: a = 12'h102;
        6: a = 12'h024; default: a = 12'h0FF;
      endcase
      d = (($urandom % 4) == 0) ? $urandom : ($urandom % 12);
      cyc("R4", ($urandom % 5) == 0, a, d, ($urandom % 3) == 0);
    end

    finish_run();
  end
endmodule